// File: doc/BRIEF.md
# Bus Reset and Keyboard-Line Activity Detector

This block watches two line conditions that share one interrupt. The first is a USB bus reset, seen as a single-ended zero: D+ and D− are both LOW. The second is activity on a PS/2 data line, seen as a long continuous LOW. Both line inputs arrive already synchronized to `clk`. The block samples them only on a slow timebase tick, which is produced internally once every `TICK_DIV` clocks. A condition must persist for a programmable number of ticks before it counts, so short glitches are filtered out.

The two events latch the interrupt at different points. A USB reset sets the pending flag at the tick after the single-ended zero has gone away. PS/2 activity sets it at the tick where the LOW first reaches its threshold, while the line is still LOW, and only once for each continuous LOW period. From the tick where either condition qualifies until the tick that sees it released, `addr_clr` stays high so that the device address register is held at zero. A status bit records which event caused the last accepted interrupt. Software clears the pending flag with a one-cycle write-one-to-clear strobe. Events that occur while the enable input is LOW are discarded.

Top module: `busrst_ps2_detect`

## Requirements
- R1: While `rst_n` is LOW, and directly after reset, `irq_pend`, `addr_clr` and `evt_is_ps2` are all 0.
- R2: The lines are sampled once per tick. A tick occurs at the rising clock edges numbered TICK_DIV, 2·TICK_DIV and so on, counted from the release of reset. Single-ended zero means `dp_s`=0 and `dn_s`=0. PS/2 LOW means `kbd_data_s`=0.
- R3: A single-ended zero sampled on fewer than SE0_TICKS consecutive ticks is ignored: it neither sets `irq_pend` nor raises `addr_clr`.
- R4: Once a single-ended zero has been sampled on at least SE0_TICKS consecutive ticks, `irq_pend` is set at the first tick that samples the lines out of that state, and not before. In the same edge, `evt_is_ps2` becomes 0.
- R5: A PS/2 LOW sets `irq_pend` at the tick where it is sampled LOW for the PS2_TICKS-th consecutive time, while the line is still LOW. In the same edge, `evt_is_ps2` becomes 1.
- R6: During one continuous PS/2 LOW period, `irq_pend` is set at most once. After it has been cleared, further ticks of the same LOW do not set it again.
- R7: `addr_clr` is 1 from the tick where a condition meets its threshold until the tick that samples that condition released, and 0 at every other time.
- R8: If `irq_en` is 0 in the cycle an event would be latched, the event is dropped, and both `irq_pend` and `evt_is_ps2` keep their values.
- R9: A 1 on `pend_w1c` clears `irq_pend` at the next clock edge. If an event is latched in that same edge, the set takes priority and `irq_pend` becomes 1.
- R10: If a USB reset end and a PS/2 threshold fall on the same tick, `irq_pend` is set and `evt_is_ps2` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dp_s | input | 1 | Synchronized USB D+ line |
| dn_s | input | 1 | Synchronized USB D− line |
| kbd_data_s | input | 1 | Synchronized PS/2 data line |
| irq_en | input | 1 | Enable for the shared interrupt |
| pend_w1c | input | 1 | Write-one-to-clear strobe for the pending flag |
| irq_pend | output | 1 | Shared interrupt pending flag |
| addr_clr | output | 1 | Holds the device address register at zero while high |
| evt_is_ps2 | output | 1 | Source of the last accepted event: 1 = PS/2, 0 = USB reset |

## Verification
Some rules are checked by the assertions on every cycle. The pending flag rises only when enable was high on the previous cycle, and it falls only after a clear strobe. A USB-sourced set is seen only after the single-ended zero has gone, and a PS/2-sourced set only while the data line is LOW. `addr_clr` rises only from a LOW line condition, and the source bit changes only together with a latched event. The exact tick on which each event lands needs the bench's tick-aligned scenarios, and so do the glitch threshold, the once-per-LOW rule, the set-over-clear priority and the coincident-event tie-break.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic {
    SRC_USB = 1'b0,
    SRC_PS2 = 1'b1
  } evt_src_e;
endpackage

// File: rtl/bpd_tick_gen.sv
module bpd_tick_gen #(
  parameter int TICK_DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bpd_low_run.sv
// Counts consecutive ticks on which a line condition is seen, saturating
// at the threshold. Reports the threshold crossing and the release.
module bpd_low_run #(
  parameter int THRESH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cond,
  output logic qual,
  output logic reach,
  output logic gone
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [CW-1:0] TH    = CW'(THRESH);
  localparam logic [CW-1:0] TH_M1 = CW'(THRESH - 1);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;

  always_comb begin
    qual   = (run_q == TH);
    reach  = tick & cond & (run_q == TH_M1);
    gone   = tick & ~cond & qual;
    run_en = tick;
    run_d  = run_q;
    if (!cond)      run_d = '0;
    else if (!qual) run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (run_en) run_q <= run_d;
  end
endmodule

// File: rtl/bpd_irq_latch.sv
module bpd_irq_latch
  import bpd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     usb_end,
  input  logic     ps2_start,
  input  logic     irq_en,
  input  logic     pend_w1c,
  output logic     pend,
  output evt_src_e src
);
  logic     pend_q, pend_d;
  evt_src_e src_q, src_d;
  logic     accept;

  always_comb begin
    accept = (usb_end | ps2_start) & irq_en;
    pend_d = pend_q;
    src_d  = src_q;
    if (accept) begin
      pend_d = 1'b1;
      src_d  = ps2_start ? SRC_PS2 : SRC_USB;
    end else if (pend_w1c) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      src_q  <= SRC_USB;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_d;
    end
  end

  assign pend = pend_q;
  assign src  = src_q;
endmodule

// File: rtl/busrst_ps2_detect.sv
module busrst_ps2_detect
  import bpd_pkg::*;
#(
  parameter int TICK_DIV  = 48,
  parameter int SE0_TICKS = 4,
  parameter int PS2_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_s,
  input  logic dn_s,
  input  logic kbd_data_s,
  input  logic irq_en,
  input  logic pend_w1c,
  output logic irq_pend,
  output logic addr_clr,
  output logic evt_is_ps2
);
  localparam int NCH = 2;
  localparam int CH_USB = 0;
  localparam int CH_PS2 = 1;

  logic            tick;
  logic [NCH-1:0]  cond, qual, reach, gone;
  evt_src_e        src;

  assign cond[CH_USB] = ~dp_s & ~dn_s;
  assign cond[CH_PS2] = ~kbd_data_s;

  bpd_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int TH = (c == CH_USB) ? SE0_TICKS : PS2_TICKS;
    bpd_low_run #(.THRESH(TH)) u_run (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cond(cond[c]),
      .qual(qual[c]), .reach(reach[c]), .gone(gone[c])
    );
  end

  bpd_irq_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .usb_end(gone[CH_USB]), .ps2_start(reach[CH_PS2]),
    .irq_en(irq_en), .pend_w1c(pend_w1c),
    .pend(irq_pend), .src(src)
  );

  assign addr_clr   = |qual;
  assign evt_is_ps2 = (src == SRC_PS2);
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker (
  input logic clk,
  input logic rst_n,
  input logic dp_s,
  input logic dn_s,
  input logic kbd_data_s,
  input logic irq_en,
  input logic pend_w1c,
  input logic irq_pend,
  input logic addr_clr,
  input logic evt_is_ps2
);
  AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(irq_en)); // R8
  AST_USB_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_pend) && !evt_is_ps2) |-> ($past(dp_s) || $past(dn_s))); // R4
  AST_PS2_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_pend) && evt_is_ps2) |-> !$past(kbd_data_s)); // R5
  AST_CLEAR_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pend) |-> $past(pend_w1c)); // R9
  AST_ADDRCLR_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_clr) |-> ((!$past(dp_s) && !$past(dn_s)) || !$past(kbd_data_s))); // R7
  AST_SRC_WITH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(evt_is_ps2) |-> irq_pend); // R4
endmodule

bind busrst_ps2_detect bpd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dp_s(dp_s), .dn_s(dn_s),
  .kbd_data_s(kbd_data_s), .irq_en(irq_en), .pend_w1c(pend_w1c),
  .irq_pend(irq_pend), .addr_clr(addr_clr), .evt_is_ps2(evt_is_ps2)
);

// File: tb/busrst_ps2_detect_bench.sv
`timescale 1ns/1ps
module busrst_ps2_detect_bench;
  localparam int TD   = 4;
  localparam int SE0T = 3;
  localparam int PS2T = 5;

  logic clk = 1'b0;
  logic rst_n, dp_s, dn_s, kbd_data_s, irq_en, pend_w1c;
  logic irq_pend, addr_clr, evt_is_ps2;
  int   n_chk = 0;
  int   n_err = 0;
  int   ncyc  = 0;

  always #5 clk = ~clk;

  busrst_ps2_detect #(.TICK_DIV(TD), .SE0_TICKS(SE0T), .PS2_TICKS(PS2T)) u_busrst_ps2_detect (
    .clk(clk), .rst_n(rst_n), .dp_s(dp_s), .dn_s(dn_s), .kbd_data_s(kbd_data_s),
    .irq_en(irq_en), .pend_w1c(pend_w1c), .irq_pend(irq_pend),
    .addr_clr(addr_clr), .evt_is_ps2(evt_is_ps2)
  );

  task automatic check(string req, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, got, exp, ncyc);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ncyc++;
    end
  endtask

  task automatic align();
    while (ncyc % TD != 0) cyc(1);
  endtask

  task automatic clr_pulse();
    pend_w1c = 1'b1; cyc(1); pend_w1c = 1'b0;
  endtask

  function automatic bit usb_fires(int n, bit en);
    return en && (n >= SE0T);
  endfunction

  function automatic bit ps2_pend_exp(int k, bit en, bit cleared);
    return en && (k >= PS2T) && !cleared;
  endfunction

  // SE0 for n ticks, then release; optional clear strobe over the end tick
  task automatic run_se0(int n, bit en, bit clr_over);
    int old_src;
    bit fire;
    clr_pulse();
    irq_en = en;
    align();
    dp_s = 1'b0; dn_s = 1'b0;
    cyc(n * TD);
    check("R3/R7", "addr_clr during SE0", addr_clr, int'(n >= SE0T));
    old_src = evt_is_ps2;
    dp_s = 1'b1;
    if (clr_over) pend_w1c = 1'b1;
    cyc(TD - 1);
    check("R4", "pend before end tick", irq_pend, 0);
    cyc(1);
    pend_w1c = 1'b0;
    fire = usb_fires(n, en);
    check(clr_over ? "R9" : "R4/R8", "pend after end tick", irq_pend, int'(fire));
    check("R7", "addr_clr after release", addr_clr, 0);
    check("R4/R8", "source bit", evt_is_ps2, fire ? 0 : old_src);
  endtask

  // PS/2 LOW for n ticks; clears the pending flag one tick after it fires
  task automatic run_ps2(int n, bit en);
    int old_src;
    bit cleared = 1'b0;
    clr_pulse();
    irq_en = en;
    old_src = evt_is_ps2;
    align();
    kbd_data_s = 1'b0;
    for (int k = 1; k <= n; k++) begin
      if (k == PS2T + 1) begin
        clr_pulse(); cyc(TD - 1); cleared = 1'b1;
      end else begin
        cyc(TD);
      end
      check(k > PS2T ? "R6" : "R5/R8", "pend during LOW", irq_pend,
            int'(ps2_pend_exp(k, en, cleared)));
      check("R7", "addr_clr during LOW", addr_clr, int'(k >= PS2T));
      if (k == PS2T)
        check("R5/R8", "source bit", evt_is_ps2, en ? 1 : old_src);
    end
    kbd_data_s = 1'b1;
    cyc(TD);
    check("R7", "addr_clr after PS/2 release", addr_clr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BD5_1C3A));
    rst_n = 1'b0; dp_s = 1'b1; dn_s = 1'b0; kbd_data_s = 1'b1;
    irq_en = 1'b1; pend_w1c = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "pend in reset", irq_pend, 0);
    check("R1", "addr_clr in reset", addr_clr, 0);
    check("R1", "source in reset", evt_is_ps2, 0);
    rst_n = 1'b1;
    ncyc = 0;
    cyc(1);
    check("R1", "pend after reset", irq_pend, 0);

    // R2: SE0 needs both lines LOW; D- alone LOW is idle
    align();
    dp_s = 1'b1; dn_s = 1'b0; cyc(2 * SE0T * TD);
    check("R2", "addr_clr with only D- LOW", addr_clr, 0);
    dp_s = 1'b0; dn_s = 1'b1; cyc(2 * SE0T * TD);
    check("R2", "addr_clr with only D+ LOW", addr_clr, 0);
    dp_s = 1'b1; dn_s = 1'b0;

    run_se0(SE0T - 1, 1'b1, 1'b0);   // R3 glitch just below threshold
    run_se0(SE0T, 1'b1, 1'b0);       // R4 exact threshold
    run_ps2(PS2T - 1, 1'b1);         // R5 just short
    run_ps2(PS2T + 4, 1'b1);         // R5 and R6 long LOW
    run_se0(SE0T + 2, 1'b0, 1'b0);   // R8 disabled
    run_ps2(PS2T, 1'b0);             // R8 disabled
    run_se0(SE0T + 1, 1'b1, 1'b1);   // R9 set beats clear

    // R10: USB end and PS/2 threshold on the same tick
    clr_pulse();
    irq_en = 1'b1;
    align();
    dp_s = 1'b0; dn_s = 1'b0;
    cyc(SE0T * TD);
    kbd_data_s = 1'b0;
    cyc((PS2T - 1) * TD);
    check("R10", "pend before shared tick", irq_pend, 0);
    dp_s = 1'b1;
    cyc(TD);
    check("R10", "pend on shared tick", irq_pend, 1);
    check("R10", "PS/2 wins the source bit", evt_is_ps2, 1);
    check("R7", "addr_clr held by PS/2 LOW", addr_clr, 1);
    kbd_data_s = 1'b1;
    cyc(TD);

    for (int t = 0; t < 14; t++) begin
      bit en = ($urandom % 4) != 0;
      if ($urandom % 2) run_se0(1 + int'($urandom % (2 * SE0T)), en, 1'b0);
      else              run_ps2(1 + int'($urandom % (2 * PS2T)), en);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule